// File: doc/BRIEF.md
# Programmed I/O Keyboard and Printer Flag Controller

This block sits beside a 12-bit processor and serves the I/O transfer instructions, which are the words whose top three bits hold the value 6. Each instruction names a device and a three-bit function. The block serves two character devices, a keyboard at device 3 and a printer at device 4. Each device has a ready flag and an 8-bit character buffer. In the cycle the processor presents an instruction, the block returns the updated accumulator and a skip request. Flag and buffer changes take effect at the next clock edge.

A character arriving from outside loads the keyboard buffer and raises the keyboard flag. The processor polls the flag with a skip instruction, then reads the character into the low eight accumulator bits. For output, the processor moves the low eight accumulator bits into the printer buffer. The block presents that character on a one-cycle output strobe, and a done pulse from the printer raises the printer flag again. The processor never sees accumulator bits 11..8 move, except when a keyboard function clears them.

Top module: `pio_flag_ctrl`

## Requirements
- R1: After reset both device flags are 0 and `prt_valid` is 0, so a skip instruction to either device requests no skip until a flag is raised.
- R2: An instruction is acted on only when `io_valid` is 1 and `io_instr[11:9]` is 6. The device number is `io_instr[8:3]`, where 3 selects the keyboard and 4 the printer, and the function is `io_instr[2:0]`. Any other opcode or device number gives `io_ac_out == io_ac_in` and `io_skip == 0`, and changes no flag or buffer.
- R3: When function bit 0 is 1, `io_skip` equals the addressed device's flag as it stands before the clock edge. The answer comes back in the same cycle.
- R4: For the keyboard, function 0 clears the flag. Function bit 1 clears the flag and sets all 12 accumulator bits to 0.
- R5: For the keyboard, function bit 2 ORs the keyboard buffer into `io_ac_out[7:0]`. When bit 1 is also set, the OR follows the clear, so the result is `{4'b0, buffer}`. Without bit 1, `io_ac_out[11:8]` equals `io_ac_in[11:8]`.
- R6: When `kbd_valid` is 1, `kbd_data` is loaded into the keyboard buffer and the flag is set. This overwrites any unread character, and it wins over a flag clear in the same cycle.
- R7: For the printer, function 0 sets the flag and function bit 1 clears it. Printer instructions never change the accumulator.
- R8: For the printer, function bit 2 captures `io_ac_in[7:0]`. In the next cycle `prt_valid` is 1 for exactly one cycle and `prt_data` holds that byte. `prt_data` keeps the byte afterwards.
- R9: When `prt_done` is 1, the printer flag is set at the next edge. This wins over a flag clear in the same cycle.
- R10: With `io_valid` at 0, the instruction word has no effect. The accumulator passes through unchanged and no skip is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | An instruction is presented this cycle |
| io_instr | input | 12 | Instruction word |
| io_ac_in | input | 12 | Accumulator value before the instruction |
| io_ac_out | output | 12 | Accumulator value after the instruction |
| io_skip | output | 1 | Skip request for the processor |
| kbd_valid | input | 1 | A character arrives from the keyboard |
| kbd_data | input | 8 | Arriving keyboard character |
| prt_valid | output | 1 | One-cycle strobe carrying a character to the printer |
| prt_data | output | 8 | Printer buffer contents |
| prt_done | input | 1 | The printer has finished a character |

## Verification
The bench aims at the same-cycle collisions:
- A keyboard arrival during a flag-clearing read must leave the flag set. A design that lets the clear win loses the character.
- A done pulse during a printer clear must also leave the flag set.

Several cases check the order and reach of the keyboard actions:
- For the clear-and-read function, a design that ORs before clearing returns zero instead of the character.
- For the static read, a design that disturbs bits 11..8 corrupts the accumulator.

Foreign devices, other opcodes and an idle `io_valid` are mixed into a long random stream, which would expose a decoder that matches on partial device bits. The output strobe's exact cycle and byte are compared every clock against the model.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int WORD_W  = 12;
  localparam int CHAR_W  = 8;
  localparam int OPC_W   = 3;
  localparam int DEV_W   = 6;
  localparam int FN_W    = 3;
  localparam logic [OPC_W-1:0] OPC_IO  = 3'd6;
  localparam logic [DEV_W-1:0] DEV_KBD = 6'd3;
  localparam logic [DEV_W-1:0] DEV_PRT = 6'd4;

  typedef struct packed {
    logic skip;
    logic clr;
    logic xfer;
    logic none;
  } fn_bits_t;

  // Split a function code into its independent action bits.
  function automatic fn_bits_t split_fn(input logic [FN_W-1:0] fn);
    fn_bits_t r;
    r.skip = fn[0];
    r.clr  = fn[1];
    r.xfer = fn[2];
    r.none = (fn == '0);
    return r;
  endfunction

  // Keyboard accumulator result: the clear happens first, then the OR of the character.
  function automatic logic [WORD_W-1:0] kbd_ac(input logic [WORD_W-1:0] ac,
                                               input logic [CHAR_W-1:0] chr,
                                               input logic clr, input logic rd);
    logic [WORD_W-1:0] t;
    t = clr ? '0 : ac;
    if (rd) t[CHAR_W-1:0] = t[CHAR_W-1:0] | chr;
    return t;
  endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [DEV_W-1:0] KBD_ID = DEV_KBD,
  parameter logic [DEV_W-1:0] PRT_ID = DEV_PRT
) (
  input  logic         valid,
  input  logic [W-1:0] instr,
  output logic         kbd_sel,
  output logic         prt_sel,
  output fn_bits_t     fn
);
  localparam int OPC_LSB = W - OPC_W;
  localparam int DEV_LSB = FN_W;

  logic io_op;
  logic [DEV_W-1:0] dev;

  assign io_op   = valid && (instr[W-1:OPC_LSB] == OPC_IO);
  assign dev     = instr[DEV_LSB +: DEV_W];
  assign kbd_sel = io_op && (dev == KBD_ID);
  assign prt_sel = io_op && (dev == PRT_ID);
  assign fn      = split_fn(instr[FN_W-1:0]);
endmodule

// File: rtl/pio_kbd.sv
module pio_kbd
  import pio_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int C = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  fn_bits_t     fn,
  input  logic [W-1:0] ac_in,
  input  logic         ext_valid,
  input  logic [C-1:0] ext_data,
  output logic [W-1:0] ac_out,
  output logic         skip,
  output logic         flag
);
  logic [C-1:0] buf_q;
  logic flag_clr;

  assign flag_clr = sel && (fn.none || fn.clr);
  assign skip     = sel && fn.skip && flag;
  assign ac_out   = sel ? kbd_ac(ac_in, buf_q, fn.clr, fn.xfer) : ac_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (ext_valid) begin
        buf_q <= ext_data;
        flag  <= 1'b1;
      end else if (flag_clr) begin
        flag  <= 1'b0;
      end
    end
  end

  p_arrival_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |=> flag && (buf_q == $past(ext_data)));
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ext_valid) |=> !flag);
  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !fn.clr) |-> (ac_out[W-1:C] == ac_in[W-1:C]));
  p_no_flag_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !skip);
endmodule

// File: rtl/pio_prt.sv
module pio_prt
  import pio_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int C = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  fn_bits_t     fn,
  input  logic [W-1:0] ac_in,
  input  logic         done,
  output logic         skip,
  output logic         flag,
  output logic         out_valid,
  output logic [C-1:0] out_data
);
  logic start, flag_set, flag_clr;

  assign start    = sel && fn.xfer;
  assign flag_set = done || (sel && fn.none);
  assign flag_clr = sel && fn.clr;
  assign skip     = sel && fn.skip && flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= start;
      if (start) out_data <= ac_in[C-1:0];
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  p_start_emits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid && (out_data == $past(ac_in[C-1:0])));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);
  p_done_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);
  p_no_flag_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !skip);
endmodule

// File: rtl/pio_flag_ctrl.sv
module pio_flag_ctrl
  import pio_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int C = CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         io_valid,
  input  logic [W-1:0] io_instr,
  input  logic [W-1:0] io_ac_in,
  output logic [W-1:0] io_ac_out,
  output logic         io_skip,
  input  logic         kbd_valid,
  input  logic [C-1:0] kbd_data,
  output logic         prt_valid,
  output logic [C-1:0] prt_data,
  input  logic         prt_done
);
  logic kbd_sel, prt_sel, kbd_skip, prt_skip, kbd_flag, prt_flag;
  fn_bits_t fn;
  logic [W-1:0] kbd_ac_out;

  pio_decode #(.W(W)) u_dec (
    .valid(io_valid), .instr(io_instr),
    .kbd_sel(kbd_sel), .prt_sel(prt_sel), .fn(fn)
  );

  pio_kbd #(.W(W), .C(C)) u_kbd (
    .clk(clk), .rst_n(rst_n), .sel(kbd_sel), .fn(fn), .ac_in(io_ac_in),
    .ext_valid(kbd_valid), .ext_data(kbd_data),
    .ac_out(kbd_ac_out), .skip(kbd_skip), .flag(kbd_flag)
  );

  pio_prt #(.W(W), .C(C)) u_prt (
    .clk(clk), .rst_n(rst_n), .sel(prt_sel), .fn(fn), .ac_in(io_ac_in),
    .done(prt_done), .skip(prt_skip), .flag(prt_flag),
    .out_valid(prt_valid), .out_data(prt_data)
  );

  assign io_ac_out = kbd_ac_out;
  assign io_skip   = kbd_skip | prt_skip;

  p_foreign_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_sel && !prt_sel) |-> (io_ac_out == io_ac_in) && !io_skip);
  p_idle_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> (io_ac_out == io_ac_in) && !io_skip);
  p_prt_keeps_ac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prt_sel |-> (io_ac_out == io_ac_in));
  p_one_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_sel, prt_sel}));
  p_reset_flags_r1: assert property (@(posedge clk)
    $fell(rst_n) |=> !kbd_flag && !prt_flag && !prt_valid);
endmodule

// File: tb/pio_flag_ctrl_tb.sv
module pio_flag_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0;
  logic [11:0] io_instr = '0, io_ac_in = '0, io_ac_out;
  logic io_skip, kbd_valid = 1'b0, prt_valid, prt_done = 1'b0;
  logic [7:0] kbd_data = '0, prt_data;

  int total = 0, bad = 0;
  int m_kflag = 0, m_pflag = 0, m_kbuf = 0, m_pbuf = 0, m_pv = 0;
  int lfsr = 32'h1ACE;

  always #2 clk = ~clk;

  pio_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_instr(io_instr),
    .io_ac_in(io_ac_in), .io_ac_out(io_ac_out), .io_skip(io_skip),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .prt_valid(prt_valid),
    .prt_data(prt_data), .prt_done(prt_done)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the model, advance the model, pass the edge.
  task automatic step(input string tag, input int iv, input int instr, input int ac,
                      input int kv, input int kd, input int pd);
    int e_ac, e_skip, dev, f, hit;
    @(negedge clk);
    io_valid = iv[0]; io_instr = instr[11:0]; io_ac_in = ac[11:0];
    kbd_valid = kv[0]; kbd_data = kd[7:0]; prt_done = pd[0];
    #1;
    hit = (iv != 0) && (((instr >> 9) & 7) == 6);
    dev = (instr >> 3) & 63;
    f = instr & 7;
    e_ac = ac & 12'hFFF;
    e_skip = 0;
    if (hit && dev == 3) begin
      if (f & 1) e_skip = m_kflag;
      if (f & 2) e_ac = 0;
      if (f & 4) e_ac = e_ac | m_kbuf;
    end
    if (hit && dev == 4 && (f & 1)) e_skip = m_pflag;
    check(tag, "ac", io_ac_out, e_ac);
    check(tag, "skip", io_skip, e_skip);
    check(tag, "prt_valid", prt_valid, m_pv);
    check(tag, "prt_data", prt_data, m_pbuf);
    m_pv = 0;
    if (hit && dev == 3 && (f == 0 || (f & 2))) m_kflag = 0;
    if (hit && dev == 4) begin
      if (f == 0) m_pflag = 1;
      if (f & 2) m_pflag = 0;
      if (f & 4) begin m_pv = 1; m_pbuf = ac & 8'hFF; end
    end
    if (kv) begin m_kbuf = kd & 8'hFF; m_kflag = 1; end
    if (pd) m_pflag = 1;
  endtask

  function automatic int next_rand(input int s);
    return (s >> 1) ^ ((s & 1) ? 32'hB400 : 0);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step("R1", 1, 12'o6031, 12'o0000, 0, 0, 0);
    step("R1", 1, 12'o6041, 12'o0000, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 8'h41, 0);
    step("R3", 1, 12'o6031, 12'h123, 0, 0, 0);
    step("R5", 1, 12'o6034, 12'hF00, 0, 0, 0);
    step("R3", 1, 12'o6031, 12'h000, 0, 0, 0);
    step("R5", 1, 12'o6036, 12'hABC, 0, 0, 0);
    step("R4", 1, 12'o6031, 12'h000, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 8'h11, 0);
    step("R6", 0, 0, 0, 1, 8'h22, 0);
    step("R5", 1, 12'o6034, 12'h800, 0, 0, 0);
    step("R4", 1, 12'o6032, 12'h123, 0, 0, 0);
    step("R4", 1, 12'o6031, 12'h000, 1, 8'h33, 0);
    step("R4", 1, 12'o6030, 12'h000, 0, 0, 0);
    step("R4", 1, 12'o6031, 12'h000, 0, 0, 0);
    step("R6", 1, 12'o6036, 12'h777, 1, 8'h5A, 0);
    step("R6", 1, 12'o6031, 12'h000, 0, 0, 0);
    step("R7", 1, 12'o6040, 12'h456, 0, 0, 0);
    step("R3", 1, 12'o6041, 12'h456, 0, 0, 0);
    step("R7", 1, 12'o6042, 12'h456, 0, 0, 0);
    step("R7", 1, 12'o6041, 12'h000, 0, 0, 0);
    step("R8", 1, 12'o6044, 12'h9A5, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    step("R9", 1, 12'o6046, 12'h03C, 0, 0, 1);
    step("R9", 1, 12'o6041, 12'h000, 0, 0, 0);
    step("R2", 1, 12'o6051, 12'h321, 1, 8'h77, 0);
    step("R2", 1, 12'o6036, 12'h000, 0, 0, 0);
    step("R2", 1, 12'o6236, 12'h654, 0, 0, 0);
    step("R2", 1, 12'o7036, 12'h654, 0, 0, 0);
    step("R10", 0, 12'o6032, 12'hFFF, 0, 0, 0);
    step("R10", 1, 12'o6031, 12'h000, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int dv, instr, r2;
      lfsr = next_rand(lfsr); r2 = lfsr;
      lfsr = next_rand(lfsr);
      dv = (r2 & 3) == 0 ? 5 : ((r2 & 1) ? 3 : 4);
      if ((r2 & 12'h300) == 12'h300) dv = r2 & 63;
      instr = (((r2 & 12'h40) != 0 ? 6 : 7) << 9) | (dv << 3) | ((r2 >> 4) & 7);
      step(dv == 3 ? "R5" : (dv == 4 ? "R8" : "R2"), (lfsr & 8) != 0, instr,
           lfsr & 12'hFFF, (r2 & 12'hC00) == 12'hC00, (lfsr >> 3) & 8'hFF,
           (lfsr & 12'h600) == 12'h600);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule